// File: doc/BRIEF.md
# Programmable CCD Horizontal Clock Generator

This block produces the four horizontal transfer clocks of a CCD sensor, a reset-gate clock and two sample strobes. A fast clock drives a 6-bit phase counter that divides each pixel period into 64 sub-pixel slots. Each programmable waveform has a rise slot, a fall slot and an invert bit. A 3-bit coupling code chooses how the four horizontal outputs are derived from one or two programmed waveforms. Two strobes pulse at programmable slots: one for the reference sample and one for the data sample. A 3-bit drive code per output gives an output-enable bit.

Configuration arrives through a parallel write port and is first held in a staging copy. The whole staging copy moves into the active set on the last slot of a period. The new values therefore govern the outputs from slot 0 of the next period, and no waveform changes partway through a period.

Top module: `hclk_gen`

## Requirements
- R1: `phase` resets to 0, steps by one on every clock and wraps from 63 to 0.
- R2: With rise slot P and fall slot N (P != N), the internal level of a waveform becomes 1 after the clock edge at which the counter equals P and 0 after the edge at which it equals N. A port sample taken while `phase` reads P+1 already shows the rise. Registers: address 1 = H1, 2 = H2, 3 = H3, 4 = RG. Each uses rise in bits [5:0], fall in [11:6] and invert in [12].
- R3: When the rise and fall slots are equal, the waveform keeps its previous level for the whole period.
- R4: Invert bit 1 inverts the waveform at its output. Invert bit 0 leaves it unchanged.
- R5: Coupling code 001 (address 0, bits [2:0]): H3 equals H1, and H2 and H4 both equal the inverse of H1. `h_out` is ordered {H4,H3,H2,H1}.
- R6: Coupling code 010: H1 and H2 are programmed separately, H3 copies H1 and H4 copies H2.
- R7: Coupling code 100: H1 and H3 are programmed separately, H2 is the inverse of H1 and H4 is the inverse of H3.
- R8: Codes 000, 011, 101, 110 and 111 hold all four H outputs low and raise `mode_err`. A valid code clears `mode_err`.
- R9: Address 5 holds the reference-sample slot in bits [5:0] and the data-sample slot in bits [11:6]. Each strobe is a single clock pulse, seen while `phase` reads slot+1 (mod 64). The two strobes may fire in the same cycle.
- R10: Address 6 holds the drive codes: H1 in [2:0], H2 in [5:3], H3 in [8:6], H4 in [11:9] and RG in [14:12]. Code 0 clears the matching enable and codes 1 to 7 set it.
- R11: A write takes effect from slot 0 of the period after the one in which it lands. A write in the slot-63 cycle waits one further period.
- R12: During reset all outputs are 0. The reset configuration is code 001 with every other field 0, so after reset `h_out` reads 1010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sub-pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 16 | Register write data |
| phase | output | 6 | Current sub-pixel slot |
| h_out | output | 4 | Horizontal clocks {H4,H3,H2,H1} |
| rg_out | output | 1 | Reset-gate clock |
| h_en | output | 4 | Output enables {H4,H3,H2,H1} from drive codes |
| rg_en | output | 1 | Reset-gate enable |
| shp_strb | output | 1 | Reference-sample strobe |
| shd_strb | output | 1 | Data-sample strobe |
| mode_err | output | 1 | Invalid coupling code flag |

## Verification
A register write and the end-of-period transfer can land on the same clock edge when the write is issued in the slot-63 cycle. The bench provokes this by waiting until `phase` reads 63 and writing new H1 slots in that cycle. It then checks that the next period still follows the old slots and that the period after that follows the new ones. It also places both strobes on the same slot and checks that they pulse together.

// File: rtl/hclk_pkg.sv
package hclk_pkg;
  localparam int PH_W   = 6;
  localparam int DRV_W  = 3;
  localparam int MODE_W = 3;
  localparam int DATA_W = 16;
  localparam int ADDR_W = 3;
  localparam int N_PROG = 4;   // H1, H2, H3, RG waveform generators
  localparam int N_DRV  = 5;   // H1..H4, RG

  localparam int IDX_H1 = 0;
  localparam int IDX_H2 = 1;
  localparam int IDX_H3 = 2;
  localparam int IDX_RG = 3;

  localparam logic [MODE_W-1:0] CPL_SINGLE = 3'b001;
  localparam logic [MODE_W-1:0] CPL_PAIR   = 3'b010;
  localparam logic [MODE_W-1:0] CPL_SPLIT  = 3'b100;

  localparam int A_CPL  = 0;
  localparam int A_WAVE = 1;   // first of N_PROG waveform registers
  localparam int A_SAMP = 5;
  localparam int A_DRV  = 6;

  typedef struct packed {
    logic            inv;
    logic [PH_W-1:0] fall;
    logic [PH_W-1:0] rise;
  } wave_cfg_t;

  typedef struct packed {
    logic [PH_W-1:0] dat;
    logic [PH_W-1:0] ref_s;
  } samp_cfg_t;
endpackage

// File: rtl/hclk_regs.sv
module hclk_regs
  import hclk_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [DATA_W-1:0]       wr_data,
  input  logic                    load,
  output wave_cfg_t               act_wave [N_PROG],
  output samp_cfg_t               act_samp,
  output logic [N_DRV*DRV_W-1:0]  act_drv,
  output logic [MODE_W-1:0]       act_cpl
);
  localparam int WW = $bits(wave_cfg_t);
  localparam int SW = $bits(samp_cfg_t);
  localparam int DW = N_DRV * DRV_W;

  wave_cfg_t              stg_wave [N_PROG];
  samp_cfg_t              stg_samp;
  logic [DW-1:0]          stg_drv;
  logic [MODE_W-1:0]      stg_cpl;

  for (genvar g = 0; g < N_PROG; g++) begin : g_wave
    always_ff @(posedge clk) begin
      if (rst) begin
        stg_wave[g] <= '0;
        act_wave[g] <= '0;
      end else begin
        if (wr_en && wr_addr == ADDR_W'(A_WAVE + g))
          stg_wave[g] <= wr_data[WW-1:0];
        if (load)
          act_wave[g] <= stg_wave[g];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      stg_samp <= '0;
      stg_drv  <= '0;
      stg_cpl  <= CPL_SINGLE;
      act_samp <= '0;
      act_drv  <= '0;
      act_cpl  <= CPL_SINGLE;
    end else begin
      if (wr_en && wr_addr == ADDR_W'(A_SAMP)) stg_samp <= wr_data[SW-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_DRV))  stg_drv  <= wr_data[DW-1:0];
      if (wr_en && wr_addr == ADDR_W'(A_CPL))  stg_cpl  <= wr_data[MODE_W-1:0];
      if (load) begin
        act_samp <= stg_samp;
        act_drv  <= stg_drv;
        act_cpl  <= stg_cpl;
      end
    end
  end
endmodule

// File: rtl/hclk_wave.sv
module hclk_wave
  import hclk_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic [PH_W-1:0] ph,
  input  wave_cfg_t       cfg,
  output logic            level
);
  logic lvl_q, lvl_d;

  always_comb begin
    lvl_d = lvl_q;
    if (cfg.rise != cfg.fall) begin
      if (ph == cfg.rise)      lvl_d = 1'b1;
      else if (ph == cfg.fall) lvl_d = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) lvl_q <= 1'b0;
    else     lvl_q <= lvl_d;
  end

  assign level = lvl_d ^ cfg.inv;
endmodule

// File: rtl/hclk_map.sv
module hclk_map
  import hclk_pkg::*;
(
  input  logic [MODE_W-1:0] cpl,
  input  logic              w1,
  input  logic              w2,
  input  logic              w3,
  output logic [3:0]        h,
  output logic              err
);
  always_comb begin
    err = 1'b0;
    unique case (cpl)
      CPL_SINGLE: h = {~w1, w1, ~w1, w1};
      CPL_PAIR:   h = { w2, w1,  w2, w1};
      CPL_SPLIT:  h = {~w3, w3, ~w1, w1};
      default: begin
        h   = 4'b0000;
        err = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/hclk_gen.sv
module hclk_gen
  import hclk_pkg::*;
#(
  parameter int NH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [PH_W-1:0]   phase,
  output logic [NH-1:0]     h_out,
  output logic              rg_out,
  output logic [NH-1:0]     h_en,
  output logic              rg_en,
  output logic              shp_strb,
  output logic              shd_strb,
  output logic              mode_err
);
  localparam logic [PH_W-1:0] PH_LAST = '1;

  logic [PH_W-1:0]         ph_q;
  logic                    load;
  wave_cfg_t               act_wave [N_PROG];
  samp_cfg_t               act_samp;
  logic [N_DRV*DRV_W-1:0]  act_drv;
  logic [MODE_W-1:0]       act_cpl;
  logic [N_PROG-1:0]       lvl;
  logic [3:0]              h_d;
  logic                    err_d;

  always_ff @(posedge clk) begin
    if (rst) ph_q <= '0;
    else     ph_q <= ph_q + 1'b1;
  end
  assign load  = (ph_q == PH_LAST);
  assign phase = ph_q;

  hclk_regs i_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .load(load), .act_wave(act_wave), .act_samp(act_samp), .act_drv(act_drv),
    .act_cpl(act_cpl)
  );

  for (genvar g = 0; g < N_PROG; g++) begin : g_gen
    hclk_wave i_wave (
      .clk(clk), .rst(rst), .ph(ph_q), .cfg(act_wave[g]), .level(lvl[g])
    );
  end

  hclk_map i_map (
    .cpl(act_cpl), .w1(lvl[IDX_H1]), .w2(lvl[IDX_H2]), .w3(lvl[IDX_H3]),
    .h(h_d), .err(err_d)
  );

  for (genvar g = 0; g < NH; g++) begin : g_en
    always_ff @(posedge clk) begin
      if (rst) h_en[g] <= 1'b0;
      else     h_en[g] <= |act_drv[g*DRV_W +: DRV_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      h_out    <= '0;
      rg_out   <= 1'b0;
      rg_en    <= 1'b0;
      shp_strb <= 1'b0;
      shd_strb <= 1'b0;
      mode_err <= 1'b0;
    end else begin
      h_out    <= h_d;
      rg_out   <= lvl[IDX_RG];
      rg_en    <= |act_drv[NH*DRV_W +: DRV_W];
      shp_strb <= (ph_q == act_samp.ref_s);
      shd_strb <= (ph_q == act_samp.dat);
      mode_err <= err_d;
    end
  end
endmodule

// File: rtl/hclk_gen_chk.sv
module hclk_gen_chk
  import hclk_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [PH_W-1:0]   phase,
  input logic [3:0]        h_out,
  input logic              mode_err,
  input logic              shp_strb,
  input logic              shd_strb,
  input logic [MODE_W-1:0] act_cpl
);
  logic armed;
  always_ff @(posedge clk) begin
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  assert_phase_step_R1: assert property (@(posedge clk) disable iff (rst)
    (phase != '1) |=> (phase == PH_W'($past(phase) + 1)));
  assert_phase_wrap_R1: assert property (@(posedge clk) disable iff (rst)
    (phase == '1) |=> (phase == '0));
  assert_invalid_low_R8: assert property (@(posedge clk) disable iff (rst)
    mode_err |-> (h_out == 4'b0000));
  assert_single_cpl_R5: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(act_cpl) == CPL_SINGLE) |->
      (h_out[2] == h_out[0] && h_out[1] == !h_out[0] && h_out[3] == !h_out[0]));
  assert_pair_cpl_R6: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(act_cpl) == CPL_PAIR) |-> (h_out[2] == h_out[0] && h_out[3] == h_out[1]));
  assert_split_cpl_R7: assert property (@(posedge clk) disable iff (rst || !armed)
    ($past(act_cpl) == CPL_SPLIT) |-> (h_out[1] == !h_out[0] && h_out[3] == !h_out[2]));
  assert_shp_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    shp_strb |=> !shp_strb);
  assert_shd_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    shd_strb |=> !shd_strb);
  assert_cfg_hold_R11: assert property (@(posedge clk) disable iff (rst || !armed)
    (phase != '0) |-> $stable(act_cpl));
endmodule

bind hclk_gen hclk_gen_chk i_chk (
  .clk(clk), .rst(rst), .phase(phase), .h_out(h_out), .mode_err(mode_err),
  .shp_strb(shp_strb), .shd_strb(shd_strb), .act_cpl(act_cpl)
);

// File: tb/test_hclk_gen.sv
module test_hclk_gen;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [5:0]  phase;
  logic [3:0]  h_out, h_en;
  logic        rg_out, rg_en, shp_strb, shd_strb, mode_err;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  hclk_gen i_hclk_gen (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .phase(phase), .h_out(h_out), .rg_out(rg_out), .h_en(h_en), .rg_en(rg_en),
    .shp_strb(shp_strb), .shd_strb(shd_strb), .mode_err(mode_err)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (phase %0d)", tag, act, exp, phase);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_phase(input logic [5:0] p);
    do @(negedge clk); while (phase !== p);
  endtask

  task automatic settle();
    wait_phase(6'd0);
    wait_phase(6'd0);
  endtask

  function automatic logic [15:0] wave(input int rise, input int fall, input bit inv);
    return 16'((int'(inv) << 12) | (fall << 6) | rise);
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk("R12 reset phase", 16'(phase), 16'd0);
    chk("R12 reset h_out", 16'(h_out), 16'd0);
    chk("R12 reset misc", 16'({rg_out, h_en, rg_en, shp_strb, shd_strb, mode_err}), 16'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R12 h_out after reset", 16'(h_out), 16'b1010);
    chk("R1 first step", 16'(phase), 16'd1);
    wait_phase(6'd63);
    @(negedge clk);
    chk("R1 wrap", 16'(phase), 16'd0);
  endtask

  task automatic t_edges();
    wr(3'd1, wave(10, 40, 0));
    wr(3'd4, wave(5, 20, 0));
    settle();
    wait_phase(6'd6);  chk("R2 rg rise", 16'(rg_out), 16'd1);
    wait_phase(6'd10); chk("R2 h before rise", 16'(h_out), 16'b1010);
    wait_phase(6'd11); chk("R2 h after rise R5", 16'(h_out), 16'b0101);
    wait_phase(6'd21); chk("R2 rg fall", 16'(rg_out), 16'd0);
    wait_phase(6'd40); chk("R2 h before fall", 16'(h_out), 16'b0101);
    wait_phase(6'd41); chk("R2 h after fall", 16'(h_out), 16'b1010);
  endtask

  task automatic t_hold();
    wr(3'd1, wave(62, 5, 0));
    settle();
    wait_phase(6'd20);
    wr(3'd1, wave(30, 30, 0));
    wait_phase(6'd0);
    wait_phase(6'd10); chk("R3 equal slots hold high", 16'(h_out), 16'b0101);
    wait_phase(6'd40); chk("R3 equal slots hold high late", 16'(h_out), 16'b0101);
  endtask

  task automatic t_pol();
    wr(3'd1, wave(10, 40, 1));
    wr(3'd4, wave(5, 20, 1));
    settle();
    wait_phase(6'd5);  chk("R4 inverted h low phase", 16'(h_out), 16'b0101);
    wait_phase(6'd10); chk("R4 inverted rg", 16'(rg_out), 16'd0);
    wait_phase(6'd11); chk("R4 inverted h high phase", 16'(h_out), 16'b1010);
    wait_phase(6'd25); chk("R4 inverted rg after fall", 16'(rg_out), 16'd1);
    wr(3'd1, wave(10, 40, 0));
    wr(3'd4, wave(5, 20, 0));
  endtask

  task automatic t_pair();
    wr(3'd0, 16'b010);
    wr(3'd1, wave(10, 40, 0));
    wr(3'd2, wave(30, 50, 0));
    settle();
    wait_phase(6'd20); chk("R6 h1 only", 16'(h_out), 16'b0101);
    wait_phase(6'd35); chk("R6 both", 16'(h_out), 16'b1111);
    wait_phase(6'd45); chk("R6 h2 only", 16'(h_out), 16'b1010);
  endtask

  task automatic t_split();
    wr(3'd0, 16'b100);
    wr(3'd3, wave(30, 50, 0));
    settle();
    wait_phase(6'd20); chk("R7 h1 high h3 low", 16'(h_out), 16'b1001);
    wait_phase(6'd45); chk("R7 h1 low h3 high", 16'(h_out), 16'b0110);
  endtask

  task automatic t_invalid();
    logic [2:0] bad [5] = '{3'b000, 3'b011, 3'b101, 3'b110, 3'b111};
    for (int i = 0; i < 5; i++) begin
      wr(3'd0, 16'(bad[i]));
      settle();
      wait_phase(6'd20);
      chk($sformatf("R8 code %b h_out", bad[i]), 16'(h_out), 16'd0);
      chk($sformatf("R8 code %b flag", bad[i]), 16'(mode_err), 16'd1);
    end
    wr(3'd0, 16'b001);
    settle();
    wait_phase(6'd20);
    chk("R8 flag cleared", 16'(mode_err), 16'd0);
    chk("R8 h restored", 16'(h_out), 16'b0101);
  endtask

  task automatic t_strobe();
    int cnt;
    wr(3'd5, 16'((12 << 6) | 12));
    settle();
    wait_phase(6'd12); chk("R9 strobes before", 16'({shp_strb, shd_strb}), 16'b00);
    wait_phase(6'd13); chk("R9 strobes coincide", 16'({shp_strb, shd_strb}), 16'b11);
    wait_phase(6'd14); chk("R9 strobes after", 16'({shp_strb, shd_strb}), 16'b00);
    wr(3'd5, 16'((63 << 6) | 3));
    settle();
    wait_phase(6'd63); chk("R9 dat strobe at 63 early", 16'(shd_strb), 16'd0);
    @(negedge clk);    chk("R9 dat strobe at wrap", 16'(shd_strb), 16'd1);
    cnt = 0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      if (shp_strb) cnt++;
    end
    chk("R9 one ref pulse per period", 16'(cnt), 16'd1);
  endtask

  task automatic t_drive();
    wr(3'd6, 16'h0E0B);
    settle();
    chk("R10 h enables", 16'(h_en), 16'b1011);
    chk("R10 rg enable off", 16'(rg_en), 16'd0);
    wr(3'd6, 16'h4000);
    settle();
    chk("R10 h enables off", 16'(h_en), 16'b0000);
    chk("R10 rg enable on", 16'(rg_en), 16'd1);
  endtask

  task automatic t_boundary();
    wr(3'd1, wave(10, 40, 0));
    settle();
    wait_phase(6'd15);
    wr(3'd1, wave(20, 50, 0));
    wait_phase(6'd45); chk("R11 old slots rest of period", 16'(h_out), 16'b1010);
    wait_phase(6'd15); chk("R11 new slots before rise", 16'(h_out), 16'b1010);
    wait_phase(6'd21); chk("R11 new slots after rise", 16'(h_out), 16'b0101);
    wait_phase(6'd63);
    wr(3'd1, wave(30, 60, 0));
    wait_phase(6'd25); chk("R11 write at slot 63 deferred", 16'(h_out), 16'b0101);
    wait_phase(6'd0);
    wait_phase(6'd25); chk("R11 deferred write applied low", 16'(h_out), 16'b1010);
    wait_phase(6'd31); chk("R11 deferred write applied high", 16'(h_out), 16'b0101);
  endtask

  initial begin
    t_reset();
    t_edges();
    t_hold();
    t_pol();
    t_pair();
    t_split();
    t_invalid();
    t_strobe();
    t_drive();
    t_boundary();
    done = 1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected done");
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule